// File: doc/BRIEF.md
# Bus-Programmable Countdown Watchdog

This block is a watchdog timer reached through an APB slave port. A down-counter runs in its own watchdog clock domain, which is separate from the bus clock. Software sets a reload value and sets an enable bit. The counter then counts down, one step per watchdog clock. When it reaches zero it raises a sticky interrupt and reloads itself. A write of any data to the clear register drops the interrupt and restarts the count from the reload value.

Every crossing between the two clock domains is handled inside the block. A write to the load register or to the clear register sends a toggle-encoded request into the watchdog domain. The enable bit passes through a bit synchronizer. The raw interrupt comes back through a bit synchronizer. The live count comes back through a self-refreshing handshake, so software always reads a coherent recent snapshot of the count.

Top module: `wdt_countdown_apb`

## Requirements
- R1: Register map, by byte offset: 0x00 control (bit 0 = enable, reset 0); 0x04 load (read/write, reset 0xFFFFFFFF, reads back the last value written); 0x08 current count (read-only); 0x0C clear (write-only, reads 0); 0x10 raw interrupt status (bit 0); 0x14 masked interrupt status (bit 0). Unmapped addresses read 0. Every access completes in zero wait states: `pready` is 1 and `pslverr` is 0.
- R2: A write to the load register makes the counter take the written value within a few watchdog clocks, whatever the state of the enable bit.
- R3: While enable is 0, the count holds its value, except when a load or clear write reloads it.
- R4: While enable is 1, the count decreases by exactly one on each watchdog clock while it is above zero.
- R5: While enable is 1 and the count is zero, the next watchdog clock sets the raw interrupt and reloads the count from the load register.
- R6: The raw interrupt is sticky: only a clear write deasserts it. While it stays set, the counter keeps reloading and counting down on every expiry, and never wraps past zero.
- R7: The masked status bit and the `irq` output equal the raw interrupt AND the enable bit.
- R8: A write of any data to the clear register deasserts the raw interrupt and reloads the count from the load register. If the clear arrives in the same watchdog clock as an expiry, the clear wins.
- R9: Writes to the count, raw status and masked status addresses have no effect.
- R10: A read of the count register returns the live counter value, delayed only by the return synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB bus clock |
| presetn | input | 1 | Active-low reset, bus domain |
| wclk | input | 1 | Watchdog counting clock |
| wrst_n | input | 1 | Active-low reset, watchdog domain |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| irq | output | 1 | Masked interrupt output |

## Verification
The bench builds the block with its defaults: 32-bit data, an 8-bit address, two synchronizer stages and a flopped `irq`. Its bus clock is 4 ns and its watchdog clock is 10 ns. Short reload values, such as 20 and 30, make expiry, sticky reload and clear reachable within a few hundred bus cycles. A reload value of 100000 gives a long window in which the decrement rate can be measured between two reads. Random reload values from a fixed seed, loaded with counting off, cover the full 32-bit range of the load path and the count return path.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // byte offsets of the software-visible registers
   localparam int unsigned OFS_CTRL   = 'h00;
   localparam int unsigned OFS_LOAD   = 'h04;
   localparam int unsigned OFS_COUNT  = 'h08;
   localparam int unsigned OFS_CLEAR  = 'h0C;
   localparam int unsigned OFS_RAW    = 'h10;
   localparam int unsigned OFS_MASKED = 'h14;
   // bit position of the enable flag in the control register
   localparam int unsigned CTRL_EN_BIT = 0;
endpackage

// File: rtl/wdt_bit_sync.sv
module wdt_bit_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stg;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= d;
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/wdt_pulse_sync.sv
module wdt_pulse_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic src_clk,
   input  logic src_rst_n,
   input  logic src_pulse,
   input  logic dst_clk,
   input  logic dst_rst_n,
   output logic dst_pulse
);
   logic tgl_src;
   logic tgl_dst;
   logic tgl_seen;

   always_ff @(posedge src_clk or negedge src_rst_n)
      if (!src_rst_n)     tgl_src <= 1'b0;
      else if (src_pulse) tgl_src <= ~tgl_src;

   wdt_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_tsync (
      .clk   (dst_clk),
      .rst_n (dst_rst_n),
      .d     (tgl_src),
      .q     (tgl_dst)
   );

   always_ff @(posedge dst_clk or negedge dst_rst_n)
      if (!dst_rst_n) tgl_seen <= 1'b0;
      else            tgl_seen <= tgl_dst;

   assign dst_pulse = tgl_dst ^ tgl_seen;
endmodule

// File: rtl/wdt_word_sync.sv
module wdt_word_sync #(
   parameter int unsigned W       = 32,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         src_clk,
   input  logic         src_rst_n,
   input  logic [W-1:0] src_data,
   input  logic         dst_clk,
   input  logic         dst_rst_n,
   output logic [W-1:0] dst_data
);
   logic [W-1:0] hold;
   logic         flag;
   logic         flag_dst;
   logic         seen;
   logic         ack_src;

   // capture a fresh snapshot whenever the previous one has been taken
   always_ff @(posedge src_clk or negedge src_rst_n)
      if (!src_rst_n) begin
         hold <= RST_VAL;
         flag <= 1'b0;
      end else if (ack_src == flag) begin
         hold <= src_data;
         flag <= ~flag;
      end

   wdt_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_fsync (
      .clk (dst_clk), .rst_n (dst_rst_n), .d (flag), .q (flag_dst)
   );

   always_ff @(posedge dst_clk or negedge dst_rst_n)
      if (!dst_rst_n) begin
         dst_data <= RST_VAL;
         seen     <= 1'b0;
      end else if (flag_dst != seen) begin
         dst_data <= hold;
         seen     <= flag_dst;
      end

   wdt_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_async (
      .clk (src_clk), .rst_n (src_rst_n), .d (seen), .q (ack_src)
   );
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
   parameter int unsigned W = 32
) (
   input  logic         wclk,
   input  logic         wrst_n,
   input  logic         en,
   input  logic         load_req,
   input  logic         clr_req,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic         irq_raw
);
   always_ff @(posedge wclk or negedge wrst_n)
      if (!wrst_n) begin
         count   <= '1;
         irq_raw <= 1'b0;
      end else if (clr_req) begin
         count   <= load_val;
         irq_raw <= 1'b0;
      end else if (load_req) begin
         count   <= load_val;
      end else if (en) begin
         if (count == '0) begin
            count   <= load_val;
            irq_raw <= 1'b1;
         end else begin
            count   <= count - 1'b1;
         end
      end
endmodule

// File: rtl/wdt_countdown_apb.sv
module wdt_countdown_apb
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_FLOP    = 1'b1
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic              irq
);
   localparam logic [DATA_W-1:0] LOAD_RST = '1;
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
   localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);

   generate
      if (SYNC_STAGES < 2)         begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
      if (DATA_W < 8 || DATA_W > 32) begin : g_bad_data  $error("DATA_W must be 8..32"); end
      if (ADDR_W < 5)              begin : g_bad_addr  $error("ADDR_W must cover offset 0x14"); end
   endgenerate

   // bus-domain state
   logic              ctrl_en;
   logic [DATA_W-1:0] load_q;
   logic              wr_acc;
   logic              load_wr;
   logic              clr_wr;
   logic [DATA_W-1:0] count_p;
   logic              raw_p;
   logic              masked_p;

   // watchdog-domain state
   logic              en_w;
   logic              load_req_w;
   logic              clr_req_w;
   logic [DATA_W-1:0] count_w;
   logic              raw_w;

   assign wr_acc  = psel & penable & pwrite;
   assign load_wr = wr_acc & (paddr == A_LOAD);
   assign clr_wr  = wr_acc & (paddr == A_CLEAR);
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   always_ff @(posedge pclk or negedge presetn)
      if (!presetn) begin
         ctrl_en <= 1'b0;
         load_q  <= LOAD_RST;
      end else begin
         if (wr_acc && paddr == A_CTRL) ctrl_en <= pwdata[CTRL_EN_BIT];
         if (load_wr)                   load_q  <= pwdata;
      end

   assign masked_p = raw_p & ctrl_en;

   always_comb begin
      prdata = '0;
      unique case (paddr)
         A_CTRL:   prdata[CTRL_EN_BIT] = ctrl_en;
         A_LOAD:   prdata = load_q;
         A_COUNT:  prdata = count_p;
         A_RAW:    prdata[0] = raw_p;
         A_MASKED: prdata[0] = masked_p;
         default:  prdata = '0;
      endcase
   end

   // bus -> watchdog
   wdt_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
      .clk (wclk), .rst_n (wrst_n), .d (ctrl_en), .q (en_w)
   );

   wdt_pulse_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
      .src_clk (pclk), .src_rst_n (presetn), .src_pulse (load_wr),
      .dst_clk (wclk), .dst_rst_n (wrst_n),  .dst_pulse (load_req_w)
   );

   wdt_pulse_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
      .src_clk (pclk), .src_rst_n (presetn), .src_pulse (clr_wr),
      .dst_clk (wclk), .dst_rst_n (wrst_n),  .dst_pulse (clr_req_w)
   );

   // counter; load_q is quasi-static by the time a request arrives
   wdt_core #(.W(DATA_W)) u_core (
      .wclk     (wclk),
      .wrst_n   (wrst_n),
      .en       (en_w),
      .load_req (load_req_w),
      .clr_req  (clr_req_w),
      .load_val (load_q),
      .count    (count_w),
      .irq_raw  (raw_w)
   );

   // watchdog -> bus
   wdt_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_raw_sync (
      .clk (pclk), .rst_n (presetn), .d (raw_w), .q (raw_p)
   );

   wdt_word_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL(LOAD_RST)) u_cnt_sync (
      .src_clk (wclk), .src_rst_n (wrst_n),  .src_data (count_w),
      .dst_clk (pclk), .dst_rst_n (presetn), .dst_data (count_p)
   );

   generate
      if (IRQ_FLOP) begin : g_irq_ff
         always_ff @(posedge pclk or negedge presetn)
            if (!presetn) irq <= 1'b0;
            else          irq <= masked_p;
      end else begin : g_irq_comb
         assign irq = masked_p;
      end
   endgenerate
endmodule

// File: rtl/wdt_countdown_apb_chk.sv
module wdt_countdown_apb_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              wclk,
   input logic              wrst_n,
   input logic              en_w,
   input logic              load_req_w,
   input logic              clr_req_w,
   input logic [DATA_W-1:0] load_q,
   input logic [DATA_W-1:0] count_w,
   input logic              raw_w
);
   logic quiet;
   assign quiet = !load_req_w && !clr_req_w;

   assert_load_takes_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
      (load_req_w && !clr_req_w) |=> count_w == $past(load_q));

   assert_hold_off_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
      (quiet && !en_w) |=> ($stable(count_w) && $stable(raw_w)));

   assert_step_down_R4: assert property (@(posedge wclk) disable iff (!wrst_n)
      (quiet && en_w && count_w != '0) |=> count_w == $past(count_w) - 1'b1);

   assert_expire_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
      (quiet && en_w && count_w == '0) |=> (raw_w && count_w == $past(load_q)));

   assert_sticky_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
      (raw_w && !clr_req_w) |=> raw_w);

   assert_clear_wins_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
      clr_req_w |=> (!raw_w && count_w == $past(load_q)));
endmodule

bind wdt_countdown_apb wdt_countdown_apb_chk #(.DATA_W(DATA_W)) u_chk (
   .wclk       (wclk),
   .wrst_n     (wrst_n),
   .en_w       (en_w),
   .load_req_w (load_req_w),
   .clr_req_w  (clr_req_w),
   .load_q     (load_q),
   .count_w    (count_w),
   .raw_w      (raw_w)
);

// File: tb/wdt_countdown_apb_tb.sv
module wdt_countdown_apb_tb;
   localparam int DW = 32;
   localparam int AW = 8;

   logic          pclk = 1'b0;
   logic          wclk = 1'b0;
   logic          presetn = 1'b0;
   logic          wrst_n  = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [DW-1:0] pwdata = '0;
   logic [DW-1:0] prdata;
   logic          pready, pslverr, irq;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   always #2 pclk = ~pclk;   // 250 MHz bus clock
   always #5 wclk = ~wclk;   // 100 MHz watchdog clock

   wdt_countdown_apb u_dut (
      .pclk (pclk), .presetn (presetn), .wclk (wclk), .wrst_n (wrst_n),
      .psel (psel), .penable (penable), .pwrite (pwrite), .paddr (paddr),
      .pwdata (pwdata), .prdata (prdata), .pready (pready),
      .pslverr (pslverr), .irq (irq)
   );

   function automatic logic exp_masked(input logic raw, input logic en);
      return raw & en;
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input logic [DW-1:0] act,
                          input logic [DW-1:0] lo, input logic [DW-1:0] hi);
      vectors++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h..%h", req, act, lo, hi);
      end
   endtask

   task automatic pwait(input int n);
      repeat (n) @(posedge pclk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(posedge pclk); #1;
      psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
      @(posedge pclk); #1;
      penable = 1;
      @(negedge pclk);
      chk("R1 pready/pslverr on write", {30'd0, pready, pslverr}, 32'h2);
      @(posedge pclk); #1;
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(posedge pclk); #1;
      psel = 1; pwrite = 0; penable = 0; paddr = a;
      @(posedge pclk); #1;
      penable = 1;
      @(negedge pclk);
      d = prdata;
      @(posedge pclk); #1;
      psel = 0; penable = 0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog timeout actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v, c1, c2, ld;
      int unsigned   seed;
      seed = $urandom(32'd1234);

      pwait(5);
      presetn = 1; wrst_n = 1;
      pwait(60);

      // reset state
      rd(8'h04, v); chk("R1 load reset", v, 32'hFFFF_FFFF);
      rd(8'h00, v); chk("R1 ctrl reset", v, 32'h0);
      rd(8'h10, v); chk("R1 raw reset", v, 32'h0);
      rd(8'h14, v); chk("R1 masked reset", v, 32'h0);
      rd(8'h0C, v); chk("R1 clear reads zero", v, 32'h0);
      rd(8'h20, v); chk("R1 unmapped reads zero", v, 32'h0);
      rd(8'h08, v); chk("R10 count reset", v, 32'hFFFF_FFFF);
      @(negedge pclk); chk("R7 irq reset", {31'd0, irq}, 32'h0);

      // random loads with counting off: load readback and count follow exactly
      for (int i = 0; i < 8; i++) begin
         ld = $urandom;
         wr(8'h04, ld);
         pwait(60);
         rd(8'h04, v); chk("R1 load readback", v, ld);
         rd(8'h08, v); chk("R2 R10 count takes load", v, ld);
      end

      // decrement rate
      wr(8'h00, 32'h1);
      wr(8'h04, 32'd100000);
      pwait(60);
      rd(8'h08, c1);
      chk_rng("R2 loaded while enabled", c1, 32'd99900, 32'd100000);
      pwait(100);   // 400 ns = 40 watchdog clocks
      rd(8'h08, c2);
      chk_rng("R4 decrement per wclk", c1 - c2, 32'd28, 32'd52);

      // hold with enable off
      wr(8'h00, 32'h0);
      pwait(60);
      rd(8'h08, c1);
      pwait(100);
      rd(8'h08, c2);
      chk("R3 count holds when disabled", c2, c1);

      // expiry and sticky reload
      wr(8'h04, 32'd20);
      pwait(40);
      wr(8'h00, 32'h1);
      pwait(150);
      rd(8'h10, v); chk("R5 raw set on expiry", v, 32'h1);
      rd(8'h14, v); chk("R7 masked with enable", v, {31'd0, exp_masked(1'b1, 1'b1)});
      @(negedge pclk); chk("R7 irq with enable", {31'd0, irq}, 32'h1);
      for (int i = 0; i < 5; i++) begin
         pwait(37 + 13 * i);
         rd(8'h08, v); chk_rng("R6 reloads without clear", v, 32'd0, 32'd20);
      end
      rd(8'h10, v); chk("R6 raw stays sticky", v, 32'h1);

      // masking and ignored writes
      wr(8'h00, 32'h0);
      pwait(60);
      rd(8'h14, v); chk("R7 masked off", v, {31'd0, exp_masked(1'b1, 1'b0)});
      rd(8'h10, v); chk("R7 raw unaffected by mask", v, 32'h1);
      @(negedge pclk); chk("R7 irq off", {31'd0, irq}, 32'h0);
      rd(8'h08, c1);
      wr(8'h08, $urandom);
      wr(8'h10, 32'h0);
      wr(8'h14, 32'h0);
      pwait(60);
      rd(8'h08, v); chk("R9 count write ignored", v, c1);
      rd(8'h10, v); chk("R9 raw write ignored", v, 32'h1);

      // clear with random data: drops raw, reloads count
      wr(8'h0C, $urandom);
      pwait(60);
      rd(8'h10, v); chk("R8 raw cleared", v, 32'h0);
      rd(8'h08, v); chk("R8 count reloaded", v, 32'd20);
      pwait(100);
      rd(8'h10, v); chk("R8 stays clear", v, 32'h0);

      // second expiry then clear with counting on
      wr(8'h04, 32'd30);
      pwait(40);
      wr(8'h00, 32'h1);
      pwait(200);
      rd(8'h10, v); chk("R5 second expiry", v, 32'h1);
      wr(8'h0C, 32'h0);
      pwait(8);
      rd(8'h10, v); chk("R8 clear while counting", v, 32'h0);
      rd(8'h08, v); chk_rng("R8 count after clear", v, 32'd1, 32'd30);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule